// File: doc/BRIEF.md
# Serial Packet Transmit Framer

This block turns bytes from a show-ahead transmit queue into the serial symbol stream of one radio packet. On a start strobe it latches its configuration and then, one symbol per symbol-enable tick, sends the following in order: a preamble of alternating ones and zeros, a two-byte sync word, an optional length byte, the payload, and an optional two-byte checksum. Two codings can be switched on for the outgoing stream. The first is pseudo-random whitening of everything after the sync word. The second is Manchester coding of every bit.

The preamble length is set by a 3-bit pseudo-floating index. Preamble and sync can be left out entirely. In that case the packet starts directly with its data portion. The packet length comes from one of two places: a fixed configuration value, or a length byte taken from the head of the queue. If the queue runs dry when a byte is needed, the block flags an underflow and gives up the packet.

Top module: `pkt_tx_framer`

## Requirements
- R1: A start pulse while idle makes busy high in the next cycle and latches every configuration input. A start pulse while busy is ignored. Configuration changes while busy do not alter the packet being sent.
- R2: With sync enabled, the packet opens with N bytes of 0xAA, where N = (2 + idx[0]) << idx[2:1] for preamble index idx. This gives 2, 3, 4, 6, 8, 12, 16 or 24 bytes.
- R3: After the preamble comes the 16-bit sync word, high byte first. Every byte of the packet is sent MSB first. With sync disabled, both the preamble and the sync word are omitted.
- R4: In variable mode, the first queue byte is the length L (1..255). L is sent as a byte and is followed by L payload bytes. L counts neither itself nor the checksum.
- R5: In fixed mode, no length byte is sent, and exactly cfg_len payload bytes (1..255) are taken from the queue.
- R6: With the checksum enabled, a CRC-16 is appended high byte first. It uses polynomial 0x8005 and seed 0xFFFF, is shifted MSB first, and is computed over the length byte and payload before whitening.
- R7: With whitening enabled, every bit after the sync word is XORed with s[0] of a 9-bit register s. The register is set to all ones at each start. After each whitened bit it shifts right, with s[0]^s[5] entering at s[8]. Preamble and sync bits are never whitened.
- R8: With Manchester coding enabled, every bit of the packet, preamble and sync included, is sent as two symbols: 1 as 1 then 0, and 0 as 0 then 1.
- R9: Each symbol is presented on tx_bit with tx_strobe high for exactly one cycle, in the cycle after the tick that produced it. No symbol appears without a tick while busy.
- R10: fifo_pop is high, only in a cycle where sym_tick is high and the queue is not empty, when the block consumes fifo_data. Exactly one pop occurs per length or payload byte.
- R11: If the queue is empty when a length or payload byte is needed, underflow pulses for one cycle, busy falls in that same cycle, and no further symbol is sent.
- R12: After reset, busy, tx_strobe, underflow and fifo_pop are all low.
- R13: busy falls in the same cycle in which tx_strobe presents the last symbol of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a packet (ignored while busy) |
| sym_tick | input | 1 | Symbol-enable tick |
| cfg_pre_idx | input | 3 | Preamble length index |
| cfg_sync_en | input | 1 | 1: send preamble and sync; 0: data portion only |
| cfg_sync_word | input | 16 | Sync word, bits 15:8 sent first |
| cfg_var_len | input | 1 | 1: length byte from queue; 0: fixed length |
| cfg_len | input | 8 | Fixed payload length |
| cfg_crc_en | input | 1 | Append checksum |
| cfg_white_en | input | 1 | Enable whitening |
| cfg_manch_en | input | 1 | Enable Manchester coding |
| fifo_empty | input | 1 | Queue has no byte |
| fifo_data | input | 8 | Head byte of the queue (show-ahead) |
| fifo_pop | output | 1 | Head byte consumed at this clock edge |
| tx_bit | output | 1 | Current symbol |
| tx_strobe | output | 1 | tx_bit holds a new symbol this cycle |
| busy | output | 1 | Packet in progress |
| underflow | output | 1 | One-cycle pulse: packet abandoned on empty queue |

## Verification
The hardest situation to reach is a packet that ends while its configuration is being changed, or that underflows at an exact byte boundary after some of its bytes have already been whitened and entered the checksum. The stimulus gets there by loading the queue with fewer bytes than the packet needs, at random and in directed cases (an empty queue, and a shortage in the middle of the payload). It scrambles every configuration input and issues a second start while the packet is in flight. Tick density varies from every cycle to one in four, so that pops and Manchester half-symbols land on every phase of the clock.

// File: rtl/pkt_tx_pkg.sv
// Shared constants, phase encoding and configuration record for the
// packet transmit framer. Assumes byte-wide queue data.
package pkt_tx_pkg;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 8;
    localparam int SYNC_W    = 16;
    localparam int PRE_IDX_W = 3;
    localparam int PN_W      = 9;
    localparam int PN_TAP    = 5;
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h8005;
    localparam logic [CRC_W-1:0]  CRC_SEED = 16'hFFFF;
    localparam logic [BYTE_W-1:0] PRE_BYTE = 8'hAA;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PRE, PH_SYNC, PH_LEN, PH_PAY, PH_CRC
    } phase_e;

    typedef struct packed {
        logic [PRE_IDX_W-1:0] pre_idx;
        logic                 sync_en;
        logic [SYNC_W-1:0]    sync_word;
        logic                 var_len;
        logic [LEN_W-1:0]     len;
        logic                 crc_en;
        logic                 white_en;
        logic                 manch_en;
    } cfg_t;

    // Preamble byte count from the pseudo-floating index.
    function automatic logic [LEN_W-1:0] pre_bytes(input logic [PRE_IDX_W-1:0] idx);
        return LEN_W'((32'd2 + 32'(idx[0])) << idx[PRE_IDX_W-1:1]);
    endfunction
endpackage

// File: rtl/pkt_pn9.sv
// Whitening sequence generator: a right-shifting LFSR. It is reseeded with
// all ones on seed and advances once per step. Assumes seed and step are
// never requested in the same cycle for a meaningful step.
module pkt_pn9 #(
    parameter int W   = pkt_tx_pkg::PN_W,
    parameter int TAP = pkt_tx_pkg::PN_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic step,
    output logic bit_o
);
    logic [W-1:0] s_q;

    // Seed or advance the sequence register.
    always_ff @(posedge clk) begin
        if (!rst_n)    s_q <= '1;
        else if (seed) s_q <= '1;
        else if (step) s_q <= {s_q[0] ^ s_q[TAP], s_q[W-1:1]};
    end

    assign bit_o = s_q[0];
endmodule

// File: rtl/pkt_crc16.sv
// Bit-serial CRC register, MSB-first data. It is seeded on seed and
// absorbs din on en. Assumes seed and en are exclusive.
module pkt_crc16 #(
    parameter int            W    = pkt_tx_pkg::CRC_W,
    parameter logic [W-1:0]  POLY = pkt_tx_pkg::CRC_POLY,
    parameter logic [W-1:0]  SEED = pkt_tx_pkg::CRC_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;
    logic         fb;

    assign fb = crc_q[W-1] ^ din;

    // Seed or fold one data bit into the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= SEED;
        else if (seed) crc_q <= SEED;
        else if (en)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/pkt_tx_framer.sv
// Packet transmit framer. It sends preamble, sync, optional length byte,
// payload and optional CRC as one symbol per sym_tick, with optional
// whitening and Manchester coding. It assumes a show-ahead queue
// (fifo_data is valid while !fifo_empty), a length byte or cfg_len that is
// never zero, and configuration that is sampled only at start.
module pkt_tx_framer
    import pkt_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sym_tick,
    input  logic [PRE_IDX_W-1:0] cfg_pre_idx,
    input  logic                 cfg_sync_en,
    input  logic [SYNC_W-1:0]    cfg_sync_word,
    input  logic                 cfg_var_len,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic                 cfg_crc_en,
    input  logic                 cfg_white_en,
    input  logic                 cfg_manch_en,
    input  logic                 fifo_empty,
    input  logic [BYTE_W-1:0]    fifo_data,
    output logic                 fifo_pop,
    output logic                 tx_bit,
    output logic                 tx_strobe,
    output logic                 busy,
    output logic                 underflow
);
    localparam int SYNC_BYTES = SYNC_W / BYTE_W;
    localparam int CRC_BYTES  = CRC_W / BYTE_W;
    localparam int BIT_W      = $clog2(BYTE_W);

    cfg_t                cfg_q, cfg_in;
    phase_e              ph_q, nxt_ph, first_ph;
    logic                busy_q, half_q, last_q, end_q;
    logic                tx_bit_q, strobe_q, unf_q;
    logic [LEN_W-1:0]    idx_q, nxt_idx, len_q, pay_len;
    logic [BIT_W-1:0]    bit_q;
    logic [BYTE_W-1:0]   sh_q, src, cur;
    logic                launch, act, data_step, load, fifo_ph, starve;
    logic                wh_ph, raw, sym_data, byte_end, pkt_last;
    logic                pn_bit;
    logic [CRC_W-1:0]    crc_val;

    assign cfg_in = '{pre_idx: cfg_pre_idx, sync_en: cfg_sync_en, sync_word: cfg_sync_word,
                      var_len: cfg_var_len, len: cfg_len, crc_en: cfg_crc_en,
                      white_en: cfg_white_en, manch_en: cfg_manch_en};

    assign first_ph  = cfg_sync_en ? PH_PRE : (cfg_var_len ? PH_LEN : PH_PAY);
    assign launch    = start && !busy_q;
    assign act       = busy_q && sym_tick;
    assign data_step = act && !half_q;
    assign load      = data_step && (bit_q == '0);
    assign fifo_ph   = (ph_q == PH_LEN) || (ph_q == PH_PAY);
    assign starve    = load && fifo_ph && fifo_empty;
    assign fifo_pop  = load && fifo_ph && !fifo_empty;
    assign wh_ph     = cfg_q.white_en && (fifo_ph || ph_q == PH_CRC);
    assign byte_end  = (bit_q == BIT_W'(BYTE_W - 1));
    assign pay_len   = cfg_q.var_len ? len_q : cfg_q.len;

    // Pick the byte that starts at the current position of the packet.
    always_comb begin
        unique case (ph_q)
            PH_PRE:          src = PRE_BYTE;
            PH_SYNC:         src = (idx_q == '0) ? cfg_q.sync_word[SYNC_W-1 -: BYTE_W]
                                                 : cfg_q.sync_word[BYTE_W-1:0];
            PH_LEN, PH_PAY:  src = fifo_data;
            PH_CRC:          src = (idx_q == '0) ? crc_val[CRC_W-1 -: BYTE_W]
                                                 : crc_val[BYTE_W-1:0];
            default:         src = '0;
        endcase
    end

    assign cur      = (bit_q == '0) ? src : sh_q;
    assign raw      = cur[BYTE_W-1];
    assign sym_data = raw ^ (wh_ph & pn_bit);

    // Work out the phase and byte index that follow the current byte.
    always_comb begin
        nxt_ph   = ph_q;
        nxt_idx  = idx_q + LEN_W'(1);
        pkt_last = 1'b0;
        unique case (ph_q)
            PH_PRE: if (idx_q + LEN_W'(1) == pre_bytes(cfg_q.pre_idx)) begin
                nxt_ph  = PH_SYNC;
                nxt_idx = '0;
            end
            PH_SYNC: if (idx_q == LEN_W'(SYNC_BYTES - 1)) begin
                nxt_ph  = cfg_q.var_len ? PH_LEN : PH_PAY;
                nxt_idx = '0;
            end
            PH_LEN: begin
                nxt_ph  = PH_PAY;
                nxt_idx = '0;
            end
            PH_PAY: if (idx_q + LEN_W'(1) == pay_len) begin
                nxt_idx = '0;
                if (cfg_q.crc_en) nxt_ph = PH_CRC;
                else begin
                    nxt_ph   = PH_IDLE;
                    pkt_last = 1'b1;
                end
            end
            PH_CRC: if (idx_q == LEN_W'(CRC_BYTES - 1)) begin
                nxt_ph   = PH_IDLE;
                pkt_last = 1'b1;
            end
            default: ;
        endcase
    end

    pkt_pn9 u_pn9 (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (launch),
        .step  (data_step && !starve && wh_ph),
        .bit_o (pn_bit)
    );

    pkt_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (launch),
        .en    (data_step && !starve && fifo_ph),
        .din   (raw),
        .crc_o (crc_val)
    );

    // Packet sequencer: launch, per-tick symbol emission, end and underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cfg_q    <= '0;
            ph_q     <= PH_IDLE;
            idx_q    <= '0;
            len_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            half_q   <= 1'b0;
            last_q   <= 1'b0;
            end_q    <= 1'b0;
            tx_bit_q <= 1'b0;
            strobe_q <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            unf_q    <= 1'b0;
            if (launch) begin
                busy_q <= 1'b1;
                cfg_q  <= cfg_in;
                ph_q   <= first_ph;
                idx_q  <= '0;
                bit_q  <= '0;
                half_q <= 1'b0;
                end_q  <= 1'b0;
            end else if (act) begin
                if (half_q) begin
                    tx_bit_q <= ~last_q;
                    strobe_q <= 1'b1;
                    half_q   <= 1'b0;
                    if (end_q) busy_q <= 1'b0;
                end else if (starve) begin
                    unf_q  <= 1'b1;
                    busy_q <= 1'b0;
                    ph_q   <= PH_IDLE;
                end else begin
                    tx_bit_q <= sym_data;
                    strobe_q <= 1'b1;
                    last_q   <= sym_data;
                    half_q   <= cfg_q.manch_en;
                    sh_q     <= {cur[BYTE_W-2:0], 1'b0};
                    bit_q    <= bit_q + BIT_W'(1);
                    if (load && ph_q == PH_LEN) len_q <= fifo_data;
                    if (byte_end) begin
                        ph_q  <= nxt_ph;
                        idx_q <= nxt_idx;
                        if (pkt_last) begin
                            if (cfg_q.manch_en) end_q  <= 1'b1;
                            else                busy_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign tx_bit    = tx_bit_q;
    assign tx_strobe = strobe_q;
    assign busy      = busy_q;
    assign underflow = unf_q;
endmodule

// File: rtl/pkt_tx_framer_chk.sv
// Port-level protocol checker for the packet transmit framer, bound to
// every instance of it. Assumes the synchronous active-low reset.
module pkt_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sym_tick,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic tx_strobe,
    input logic busy,
    input logic underflow
);
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R1
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R10
    AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (busy && sym_tick)); // R10
    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(sym_tick && busy)); // R9
    AST_UNDERFLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!busy && !tx_strobe)); // R11
    AST_UNDERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow); // R11
endmodule

bind pkt_tx_framer pkt_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sym_tick   (sym_tick),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .tx_strobe  (tx_strobe),
    .busy       (busy),
    .underflow  (underflow)
);

// File: tb/pkt_tx_framer_bench.sv
// Self-checking bench: a software queue model, a packet reference model and
// a mix of directed and random packets.
module pkt_tx_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sym_tick = 1'b0;
    logic [2:0]  cfg_pre_idx = '0;
    logic        cfg_sync_en = 1'b0;
    logic [15:0] cfg_sync_word = '0;
    logic        cfg_var_len = 1'b0;
    logic [7:0]  cfg_len = 8'd1;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_white_en = 1'b0;
    logic        cfg_manch_en = 1'b0;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        fifo_pop, tx_bit, tx_strobe, busy, underflow;

    int tests = 0;
    int fails = 0;

    logic [7:0] fifo_mem [0:4095];
    int         wr = 0;
    int         rd;
    logic [7:0] pay_mem [0:255];

    bit exp_sym [0:4095];
    int exp_n, exp_pops;
    bit exp_trunc;
    bit got [0:4095];
    bit gbusy [0:4095];

    always #10 clk = ~clk;

    assign fifo_empty = (rd == wr);
    assign fifo_data  = fifo_mem[rd % 4096];

    // Queue read pointer follows the pops of the design.
    always @(posedge clk) begin
        if (!rst_n)        rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    pkt_tx_framer u_pkt_tx_framer (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_tick(sym_tick),
        .cfg_pre_idx(cfg_pre_idx), .cfg_sync_en(cfg_sync_en),
        .cfg_sync_word(cfg_sync_word), .cfg_var_len(cfg_var_len),
        .cfg_len(cfg_len), .cfg_crc_en(cfg_crc_en), .cfg_white_en(cfg_white_en),
        .cfg_manch_en(cfg_manch_en), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .tx_bit(tx_bit),
        .tx_strobe(tx_strobe), .busy(busy), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] data_byte(input bit vl, input int len, input int k);
        if (vl) return (k == 0) ? 8'(len) : pay_mem[k-1];
        return pay_mem[k];
    endfunction

    // Reference packet model built from the requirements.
    task automatic build_exp(input logic [2:0] pidx, input bit so, input logic [15:0] sw,
                             input bit vl, input int len, input bit ce, input bit we,
                             input bit me, input int avail);
        bit raw [0:4095];
        int nraw = 0;
        int hdr, ndata, cut;
        logic [15:0] crc = 16'hFFFF;
        logic [8:0]  pn = 9'h1FF;
        logic [7:0]  b;
        if (so) begin
            for (int k = 0; k < ((2 + int'(pidx[0])) << pidx[2:1]); k++)
                for (int i = 7; i >= 0; i--) raw[nraw++] = (i % 2 == 1);
            for (int i = 15; i >= 0; i--) raw[nraw++] = sw[i];
        end
        hdr   = nraw;
        ndata = vl ? len + 1 : len;
        for (int k = 0; k < ndata; k++) begin
            b = data_byte(vl, len, k);
            for (int i = 7; i >= 0; i--) begin
                raw[nraw++] = b[i];
                crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ b[i]) ? 16'h8005 : 16'h0000);
            end
        end
        if (ce) for (int i = 15; i >= 0; i--) raw[nraw++] = crc[i];
        if (we) for (int i = hdr; i < nraw; i++) begin
            raw[i] = raw[i] ^ pn[0];
            pn = {pn[0] ^ pn[5], pn[8:1]};
        end
        if (avail < ndata) begin
            exp_trunc = 1'b1;
            exp_pops  = avail;
            cut       = hdr + 8 * avail;
        end else begin
            exp_trunc = 1'b0;
            exp_pops  = ndata;
            cut       = nraw;
        end
        exp_n = 0;
        for (int i = 0; i < cut; i++) begin
            exp_sym[exp_n++] = raw[i];
            if (me) exp_sym[exp_n++] = ~raw[i];
        end
    endtask

    // Send one packet; scramble configuration and re-strobe start mid-packet.
    task automatic run_pkt(input string req, input logic [2:0] pidx, input bit so,
                           input logic [15:0] sw, input bit vl, input int len,
                           input bit ce, input bit we, input bit me,
                           input int avail, input int tick_mode);
        int ndata = vl ? len + 1 : len;
        int rd0, got_n, unf, idle_run, mism;
        int push = (avail < ndata) ? avail : ndata;
        for (int k = 0; k < push; k++) begin
            fifo_mem[wr % 4096] = data_byte(vl, len, k);
            wr++;
        end
        build_exp(pidx, so, sw, vl, len, ce, we, me, avail);
        rd0 = rd; got_n = 0; unf = 0; idle_run = 0;
        for (int cyc = 0; cyc < 40000; cyc++) begin
            @(negedge clk);
            if (cyc > 0) begin
                if (tx_strobe) begin
                    got[got_n % 4096]   = tx_bit;
                    gbusy[got_n % 4096] = busy;
                    got_n++;
                end
                if (underflow) unf++;
                if (cyc == 1) chk(busy == 1'b1, "R1", "busy after start", busy, 1);
                idle_run = busy ? 0 : idle_run + 1;
                if (idle_run >= 4) break;
            end
            start = (cyc == 0) || (cyc == 6 && busy);
            if (cyc == 0) begin
                cfg_pre_idx = pidx; cfg_sync_en = so; cfg_sync_word = sw;
                cfg_var_len = vl; cfg_len = 8'(len); cfg_crc_en = ce;
                cfg_white_en = we; cfg_manch_en = me;
            end else if (cyc <= 12) begin
                {cfg_pre_idx, cfg_sync_en, cfg_var_len, cfg_crc_en, cfg_white_en,
                 cfg_manch_en} = 8'($urandom);
                cfg_sync_word = 16'($urandom);
                cfg_len = 8'($urandom_range(1, 255));
            end
            case (tick_mode)
                0:       sym_tick = 1'b1;
                1:       sym_tick = 1'($urandom % 2);
                default: sym_tick = ($urandom % 4) == 0;
            endcase
        end
        start = 1'b0; sym_tick = 1'b0;
        chk(got_n == exp_n, req, "symbol count", got_n, exp_n);
        mism = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (mism < 0 && got[i] != exp_sym[i]) mism = i;
        chk(mism < 0, req, "first mismatching symbol index", mism, -1);
        chk(unf == int'(exp_trunc), "R11", "underflow pulses", unf, int'(exp_trunc));
        chk(rd - rd0 == exp_pops, "R10", "bytes popped", rd - rd0, exp_pops);
        if (!exp_trunc && got_n == exp_n && exp_n > 1) begin
            chk(gbusy[exp_n-1] == 1'b0, "R13", "busy at last symbol", gbusy[exp_n-1], 0);
            chk(gbusy[exp_n-2] == 1'b1, "R13", "busy before last symbol", gbusy[exp_n-2], 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(busy == 0, "R12", "busy in reset", busy, 0);
        chk(tx_strobe == 0, "R12", "strobe in reset", tx_strobe, 0);
        chk(underflow == 0, "R12", "underflow in reset", underflow, 0);
        chk(fifo_pop == 0, "R12", "pop in reset", fifo_pop, 0);
        rst_n = 1'b1;
        // R9: ticks while idle produce nothing
        begin
            int strobes = 0;
            for (int i = 0; i < 20; i++) begin
                sym_tick = 1'b1;
                @(negedge clk);
                if (tx_strobe || fifo_pop) strobes++;
            end
            sym_tick = 1'b0;
            chk(strobes == 0, "R9", "symbols while idle", strobes, 0);
        end
        for (int p = 0; p < 8; p++) begin
            pay_mem[0] = 8'(p * 37 + 5);
            run_pkt("R2", 3'(p), 1, 16'hD391, 0, 1, 0, 0, 0, 99, 0);
        end
        for (int k = 0; k < 256; k++) pay_mem[k] = 8'($urandom);
        run_pkt("R3", 3'd2, 1, 16'h1F35, 0, 3, 0, 0, 0, 99, 1);
        run_pkt("R3", 3'd5, 0, 16'hFFFF, 0, 4, 0, 0, 0, 99, 0);
        run_pkt("R4", 3'd0, 1, 16'hC0DE, 1, 9, 0, 0, 0, 99, 1);
        run_pkt("R5", 3'd1, 1, 16'h5A5A, 0, 255, 0, 0, 0, 999, 0);
        run_pkt("R6", 3'd0, 0, 16'h0000, 1, 6, 1, 0, 0, 99, 2);
        for (int k = 0; k < 256; k++) pay_mem[k] = 8'h00;
        run_pkt("R7", 3'd0, 1, 16'h0000, 0, 8, 1, 1, 0, 99, 0);
        for (int k = 0; k < 256; k++) pay_mem[k] = 8'($urandom);
        run_pkt("R8", 3'd3, 1, 16'h8001, 1, 5, 1, 1, 1, 99, 1);
        run_pkt("R11", 3'd0, 1, 16'hAAAA, 0, 4, 1, 0, 0, 0, 0);
        run_pkt("R11", 3'd1, 0, 16'h0000, 1, 10, 1, 1, 1, 5, 2);
        for (int t = 0; t < 25; t++) begin
            int   len   = $urandom_range(1, 24);
            bit   vl    = 1'($urandom);
            int   avail = (($urandom % 5) == 0) ? $urandom_range(0, len) : 999;
            for (int k = 0; k < 256; k++) pay_mem[k] = 8'($urandom);
            run_pkt("R1", 3'($urandom), 1'($urandom), 16'($urandom), vl, len,
                    1'($urandom), 1'($urandom), 1'($urandom), avail, $urandom % 3);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule